// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a bank of external interrupt inputs and presents them to a processor as one combined interrupt request and a small memory-mapped register set. Every input passes through a two-flop synchroniser. Each line can be edge-sensitive or level-sensitive, and its polarity bit picks the active edge or level. An edge-sensitive line latches an event until software acknowledges it. A level-sensitive line reports the synchronised input directly while it sits at its active level.

Mask, sensitivity, software-interrupt and polarity each have a main register that software reads, plus a write-one-to-set alias and a write-one-to-clear alias. Software changes these fields only through the aliases, one bit at a time, so it needs no read-modify-write. A domain-enable register is written directly. A line drives the combined output only when it has status, its domain-enable bit is 1 and its mask bit is 0. Software can raise any line's status on its own through the software-interrupt field.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all mask bits are 1, and the sensitivity, polarity, software-interrupt, domain-enable and status bits are all 0. `irq_o` is 0.
- R2: A 1 in a word written to mask-set (0x0C0) sets that mask bit, and a 1 written to mask-clear (0x100) clears it. Zero bits in either write leave their mask bits unchanged. Writes to the main mask register (0x080) are ignored.
- R3: Sensitivity (main 0x140, set 0x180, clear 0x1C0), software interrupt (main 0x200, set 0x240, clear 0x280) and polarity (main 0x300, set 0x340, clear 0x380) follow the same alias rules. Writes to their main registers are ignored.
- R4: Domain-enable at 0x400 is read/write. The value written is read back unchanged.
- R5: With sensitivity bit 0 (edge), a line's status bit latches on the active edge of the synchronised input. Polarity 1 selects the rising edge and polarity 0 the falling edge. The status bit stays set after the input returns.
- R6: A 1 written to acknowledge (0x040) clears that line's latched edge status. Zero bits have no effect.
- R7: With sensitivity bit 1 (level), status is 1 exactly while the synchronised input is at its active level: high for polarity 1, low for polarity 0. An acknowledge has no lasting effect while that level persists.
- R8: The software-interrupt bit of a line forces its status to 1 until a soft-clear write removes it.
- R9: Status (read at 0x000) is the hardware status OR the software-interrupt bit, taken before masking and domain enable.
- R10: `irq_o` is registered. It equals the OR over all lines of (status AND NOT mask AND domain-enable) as it stood in the previous cycle.
- R11: Address bits [11:6] select the register and bits [5:2] select the 32-bit word, so bit n of word w controls line 32·w+n. Reads of words beyond the implemented lines, or of alias and unused offsets (including acknowledge), return 0. Writes to them change nothing.
- R12: Read data appears on `rdata_o` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| line_i | input | NUM_LINES | External interrupt inputs (asynchronous) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Some properties are checked by assertions on every cycle. These are the mask alias rules: set bits become 1, cleared bits become 0, and every other write leaves the mask alone. Also checked are the immediate effect of a soft-set write on status, and the exact one-cycle relation between enabled status and `irq_o` in both directions. The directed scenarios cover the rest. They show edge capture per polarity through the synchroniser, acknowledge against edge and level lines, level tracking, domain gating, and that writes to main registers and unmapped words are ignored.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NF     = 5;  // mask, sens, soft, pol, dom

  localparam logic [5:0] GRP_STAT     = 6'd0;
  localparam logic [5:0] GRP_ACK      = 6'd1;
  localparam logic [5:0] GRP_MASK     = 6'd2;
  localparam logic [5:0] GRP_MASK_SET = 6'd3;
  localparam logic [5:0] GRP_MASK_CLR = 6'd4;
  localparam logic [5:0] GRP_SENS     = 6'd5;
  localparam logic [5:0] GRP_SENS_SET = 6'd6;
  localparam logic [5:0] GRP_SENS_CLR = 6'd7;
  localparam logic [5:0] GRP_SOFT     = 6'd8;
  localparam logic [5:0] GRP_SOFT_SET = 6'd9;
  localparam logic [5:0] GRP_SOFT_CLR = 6'd10;
  localparam logic [5:0] GRP_POL      = 6'd12;
  localparam logic [5:0] GRP_POL_SET  = 6'd13;
  localparam logic [5:0] GRP_POL_CLR  = 6'd14;
  localparam logic [5:0] GRP_DOM      = 6'd16;

  typedef enum int unsigned {
    FLD_MASK = 0,
    FLD_SENS = 1,
    FLD_SOFT = 2,
    FLD_POL  = 3,
    FLD_DOM  = 4
  } fld_e;

  function automatic logic [5:0] fld_main(input int unsigned f);
    case (f)
      FLD_MASK: return GRP_MASK;
      FLD_SENS: return GRP_SENS;
      FLD_SOFT: return GRP_SOFT;
      FLD_POL:  return GRP_POL;
      default:  return GRP_DOM;
    endcase
  endfunction

  function automatic logic [5:0] fld_set(input int unsigned f);
    case (f)
      FLD_MASK: return GRP_MASK_SET;
      FLD_SENS: return GRP_SENS_SET;
      FLD_SOFT: return GRP_SOFT_SET;
      default:  return GRP_POL_SET;
    endcase
  endfunction

  function automatic logic [5:0] fld_clr(input int unsigned f);
    case (f)
      FLD_MASK: return GRP_MASK_CLR;
      FLD_SENS: return GRP_SENS_CLR;
      FLD_SOFT: return GRP_SOFT_CLR;
      default:  return GRP_POL_CLR;
    endcase
  endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  localparam int unsigned S = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] stg_q [S];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < S; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < S; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[S-1];
    end
  end

  assign sync_o = stg_q[S-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/eirq_decode.sv
module eirq_decode
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [5:0]           grp_o,
  output logic [3:0]           wsel_o,
  output logic                 hit_o,
  output logic                 wr_o,
  output logic [NUM_LINES-1:0] wbits_o
);
  localparam int unsigned NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W     = NUM_WORDS * WORD_W;

  logic [PAD_W-1:0] pad;

  assign grp_o  = addr_i[11:6];
  assign wsel_o = addr_i[5:2];
  assign hit_o  = req_i && (addr_i[1:0] == 2'b00) && (32'(wsel_o) < NUM_WORDS);
  assign wr_o   = hit_o && we_i;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign pad[w*WORD_W +: WORD_W] = (32'(wsel_o) == w) ? wdata_i : '0;
  end

  assign wbits_o = pad[NUM_LINES-1:0];
endmodule

// File: rtl/eirq_setclr_reg.sv
module eirq_setclr_reg #(
  parameter int unsigned N        = 32,
  parameter bit          RST_ONES = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= {N{RST_ONES}};
    else if (ld_i)  q <= bits_i;
    else if (set_i) q <= q | bits_i;
    else if (clr_i) q <= q & ~bits_i;
  end

  assign q_o = q;
endmodule

// File: rtl/eirq_line_status.sv
module eirq_line_status #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] sens_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] soft_i,
  input  logic         ack_i,
  input  logic [N-1:0] ack_bits_i,
  output logic [N-1:0] status_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic edge_hit, lvl_act, edge_q;

    assign edge_hit = pol_i[i] ? (sync_i[i] & ~prev_i[i]) : (~sync_i[i] & prev_i[i]);
    assign lvl_act  = ~(sync_i[i] ^ pol_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      edge_q <= 1'b0;
      else if (sens_i[i])               edge_q <= 1'b0;
      else if (edge_hit)                edge_q <= 1'b1;  // new edge wins over ack
      else if (ack_i && ack_bits_i[i])  edge_q <= 1'b0;
    end

    assign status_o[i] = (sens_i[i] ? lvl_act : edge_q) | soft_i[i];
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_LINES-1:0] line_i,
  output logic                 irq_o
);
  localparam int unsigned NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W     = NUM_WORDS * WORD_W;

  logic [5:0]           grp;
  logic [3:0]           wsel;
  logic                 hit, wr;
  logic [NUM_LINES-1:0] wbits;

  eirq_decode #(.NUM_LINES(NUM_LINES)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .grp_o(grp), .wsel_o(wsel), .hit_o(hit), .wr_o(wr), .wbits_o(wbits)
  );

  logic [NUM_LINES-1:0] fld_q [NF];

  for (genvar f = 0; f < NF; f++) begin : g_fld
    logic set_we, clr_we, ld_we;
    if (f == FLD_DOM) begin : g_direct
      assign set_we = 1'b0;
      assign clr_we = 1'b0;
      assign ld_we  = wr && (grp == fld_main(f));
    end else begin : g_alias
      assign set_we = wr && (grp == fld_set(f));
      assign clr_we = wr && (grp == fld_clr(f));
      assign ld_we  = 1'b0;
    end
    eirq_setclr_reg #(.N(NUM_LINES), .RST_ONES(f == FLD_MASK)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_we), .clr_i(clr_we),
      .ld_i(ld_we), .bits_i(wbits), .q_o(fld_q[f])
    );
  end

  logic [NUM_LINES-1:0] mask_q, sens_q, soft_q, pol_q, dom_q;
  assign mask_q = fld_q[FLD_MASK];
  assign sens_q = fld_q[FLD_SENS];
  assign soft_q = fld_q[FLD_SOFT];
  assign pol_q  = fld_q[FLD_POL];
  assign dom_q  = fld_q[FLD_DOM];

  logic [NUM_LINES-1:0] sync_w, prev_w, status_w;

  eirq_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(line_i),
    .sync_o(sync_w), .prev_o(prev_w)
  );

  eirq_line_status #(.N(NUM_LINES)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_w), .prev_i(prev_w),
    .sens_i(sens_q), .pol_i(pol_q), .soft_i(soft_q),
    .ack_i(wr && (grp == GRP_ACK)), .ack_bits_i(wbits), .status_o(status_w)
  );

  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_w & ~mask_q & dom_q);
  end
  assign irq_o = irq_q;

  logic [PAD_W-1:0] rd_pad;
  logic [31:0]      rd_word;

  always_comb begin
    rd_pad = '0;
    case (grp)
      GRP_STAT: rd_pad[NUM_LINES-1:0] = status_w;
      GRP_MASK: rd_pad[NUM_LINES-1:0] = mask_q;
      GRP_SENS: rd_pad[NUM_LINES-1:0] = sens_q;
      GRP_SOFT: rd_pad[NUM_LINES-1:0] = soft_q;
      GRP_POL:  rd_pad[NUM_LINES-1:0] = pol_q;
      GRP_DOM:  rd_pad[NUM_LINES-1:0] = dom_q;
      default:  rd_pad = '0;
    endcase
    rd_word = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (32'(wsel) == w) rd_word = rd_pad[w*WORD_W +: WORD_W];
  end

  logic [31:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= hit ? rd_word : '0;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk #(
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [11:0]          addr_i,
  input logic [31:0]          wdata_i,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] status,
  input logic [NUM_LINES-1:0] dom_q,
  input logic                 irq_o
);
  localparam int unsigned CW = (NUM_LINES < 32) ? NUM_LINES : 32;

  logic          wr, mset, mclr, sset;
  logic [CW-1:0] wb;
  logic          any_en;

  assign wr     = req_i && we_i;
  assign mset   = wr && (addr_i == 12'h0C0);
  assign mclr   = wr && (addr_i == 12'h100);
  assign sset   = wr && (addr_i == 12'h240);
  assign wb     = wdata_i[CW-1:0];
  assign any_en = |(status & ~mask_q & dom_q);

  assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mset |=> ((mask_q[CW-1:0] & $past(wb)) == $past(wb)));

  assert_mask_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr |=> ((mask_q[CW-1:0] & $past(wb)) == '0));

  assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mset || mclr) |=> $stable(mask_q));

  assert_soft_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sset |=> ((status[CW-1:0] & $past(wb)) == $past(wb)));

  assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en |=> irq_o);

  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(any_en));
endmodule

bind ext_irq_ctrl eirq_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .mask_q(mask_q),
  .status(status_w), .dom_q(dom_q), .irq_o(irq_o)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;
  localparam logic [11:0] A_STAT = 12'h000, A_ACK = 12'h040, A_MASK = 12'h080,
    A_MSET = 12'h0C0, A_MCLR = 12'h100, A_SENS = 12'h140, A_SSET = 12'h180,
    A_SCLR = 12'h1C0, A_SOFT = 12'h200, A_FSET = 12'h240, A_FCLR = 12'h280,
    A_POL = 12'h300, A_PSET = 12'h340, A_PCLR = 12'h380, A_DOM = 12'h400;

  logic        clk = 0, rst_n = 0, req = 0, we = 0, irq;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] line = '0;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .line_i(line), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; req = 0;  // R12: valid one cycle later
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    rchk("R1 mask", A_MASK, 32'hFFFF_FFFF);
    rchk("R1 sens", A_SENS, 32'h0);
    rchk("R1 pol", A_POL, 32'h0);
    rchk("R1 soft", A_SOFT, 32'h0);
    rchk("R1 dom", A_DOM, 32'h0);
    rchk("R1 stat", A_STAT, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask();
    wr(A_MCLR, 32'hFFFF_0000);
    rchk("R2 clr", A_MASK, 32'h0000_FFFF);
    wr(A_MCLR, 32'h0);
    rchk("R2 clr zero", A_MASK, 32'h0000_FFFF);
    wr(A_MASK, 32'h0);
    rchk("R2 main ignored", A_MASK, 32'h0000_FFFF);
    wr(A_MSET, 32'h0001_0000);
    rchk("R2 set", A_MASK, 32'h0001_FFFF);
    wr(A_MSET, 32'hFFFF_FFFF);
    rchk("R2 restore", A_MASK, 32'hFFFF_FFFF);
  endtask

  task automatic t_alias();
    wr(A_SSET, 32'h0000_00A5);
    rchk("R3 sens set", A_SENS, 32'h0000_00A5);
    wr(A_SCLR, 32'h0000_0005);
    rchk("R3 sens clr", A_SENS, 32'h0000_00A0);
    wr(A_SENS, 32'hFFFF_FFFF);
    rchk("R3 sens main ignored", A_SENS, 32'h0000_00A0);
    wr(A_SCLR, 32'hFFFF_FFFF);
    wr(A_PSET, 32'h0F00_003C);
    wr(A_PCLR, 32'h0F00_0000);
    rchk("R3 pol", A_POL, 32'h0000_003C);
    wr(A_POL, 32'h0);
    rchk("R3 pol main ignored", A_POL, 32'h0000_003C);
    wr(A_PCLR, 32'hFFFF_FFFF);
    wr(A_SOFT, 32'hFFFF_FFFF);
    rchk("R3 soft main ignored", A_SOFT, 32'h0);
  endtask

  task automatic t_dom();
    wr(A_DOM, 32'h1234_5678);
    rchk("R4 R12 dom readback", A_DOM, 32'h1234_5678);
    wr(A_DOM, 32'hFFFF_FFFF);
    rchk("R4 dom all", A_DOM, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    wr(A_PSET, 32'h0000_0008);
    line[3] = 1; settle();
    rchk("R5 rising latched", A_STAT, 32'h0000_0008);
    line[4] = 1; settle();
    rchk("R5 rise ignored on falling line", A_STAT, 32'h0000_0008);
    line[3] = 0; settle();
    rchk("R5 held after input returns", A_STAT, 32'h0000_0008);
    line[4] = 0; settle();
    rchk("R5 falling latched", A_STAT, 32'h0000_0018);
    wr(A_ACK, 32'h0000_0020);
    rchk("R6 zero bits no effect", A_STAT, 32'h0000_0018);
    wr(A_ACK, 32'h0000_0008);
    rchk("R6 ack clears", A_STAT, 32'h0000_0010);
    wr(A_ACK, 32'h0000_0010);
    rchk("R6 ack all", A_STAT, 32'h0);
    wr(A_PCLR, 32'h0000_0008);
  endtask

  task automatic t_level();
    wr(A_SSET, 32'h0000_0180);
    wr(A_PSET, 32'h0000_0080);
    settle();
    rchk("R7 active-low level", A_STAT, 32'h0000_0100);
    line[7] = 1; line[8] = 1; settle();
    rchk("R7 follows input", A_STAT, 32'h0000_0080);
    wr(A_ACK, 32'h0000_0080);
    rchk("R7 ack no lasting effect", A_STAT, 32'h0000_0080);
    line[7] = 0; settle();
    rchk("R7 level gone", A_STAT, 32'h0);
    wr(A_SCLR, 32'h0000_0180);
    wr(A_PCLR, 32'h0000_0080);
    rchk("R7 back to edge no status", A_STAT, 32'h0);
  endtask

  task automatic t_soft();
    wr(A_FSET, 32'h0000_0400);
    rchk("R8 soft reg", A_SOFT, 32'h0000_0400);
    rchk("R9 status before mask", A_STAT, 32'h0000_0400);
    settle();
    chk("R10 masked", {31'b0, irq}, 32'h0);
    wr(A_MCLR, 32'h0000_0400);
    settle();
    chk("R10 unmasked", {31'b0, irq}, 32'h1);
    wr(A_DOM, 32'hFFFF_FBFF);
    settle();
    chk("R10 domain gates", {31'b0, irq}, 32'h0);
    wr(A_DOM, 32'hFFFF_FFFF);
    settle();
    chk("R10 domain restored", {31'b0, irq}, 32'h1);
    wr(A_FCLR, 32'h0000_0400);
    settle();
    rchk("R8 soft clear", A_STAT, 32'h0);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);
    wr(A_MSET, 32'h0000_0400);
  endtask

  task automatic t_irq_edge();
    wr(A_PSET, 32'h0000_1000);
    wr(A_MCLR, 32'h0000_1000);
    line[12] = 1; settle();
    chk("R10 edge irq", {31'b0, irq}, 32'h1);
    wr(A_ACK, 32'h0000_1000);
    settle();
    chk("R6 R10 ack drops irq", {31'b0, irq}, 32'h0);
    wr(A_MSET, 32'h0000_1000);
  endtask

  task automatic t_unmapped();
    wr(12'h2C0, 32'hFFFF_FFFF);
    rchk("R11 unused group", 12'h2C0, 32'h0);
    rchk("R11 ack reads zero", A_ACK, 32'h0);
    rchk("R11 alias reads zero", A_MSET, 32'h0);
    wr(12'h104, 32'hFFFF_FFFF);
    rchk("R11 word1 write ignored", A_MASK, 32'hFFFF_FFFF);
    rchk("R11 word1 read zero", 12'h084, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_alias();
    t_dom();
    t_edge();
    t_level();
    t_soft();
    t_irq_edge();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule